// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block drives write and page-erase operations into two behavioural flash arrays, a program array and a data array, and keeps reads away from an array while an operation on it runs. A write request (array select, word address, data) is taken into a single holding slot, so software can queue the next write while the current one executes; it needs to look only at the `full` output before loading. A page erase is started through a separate request that carries an address anywhere inside the page and is gated by a permit input supplied by an external protection policy.

Writing only clears bits: each stored word becomes the old word ANDed with the written data. An erase returns every word of the page to all ones. Every operation keeps `busy` high for a fixed number of cycles taken from a parameter, and the array contents change on the edge at which `busy` falls. A single read port returns words or zero-extended bytes; program-array reads stall during program-array operations and data-array reads stall during any operation.

Top module: `flash_seq`

## Requirements
- R1: After reset `full`, `busy` and `overrun` are 0 and every word of both arrays reads 16'hFFFF.
- R2: A completed write leaves the addressed word equal to its previous value ANDed with the written data; no bit ever changes from 0 to 1 through a write.
- R3: A completed erase sets every word of the page holding `erase_addr` (page index = word address divided by the array's page size in words) to 16'hFFFF and changes no other word.
- R4: `busy` rises on the clock edge that starts an operation and stays high for exactly PROG_CYCLES cycles for a write and ERASE_CYCLES cycles for an erase; the result is visible once `busy` is low again.
- R5: A write offered while `full` is 0 is held (`full` rises on the next edge) even when an operation is running; a held write starts on the edge after `busy` falls, leaving one cycle with `busy` low and `full` high, and `full` drops when it starts.
- R6: A write offered while `full` is 1 is discarded, sets the sticky `overrun` flag (cleared only by reset) and leaves the held write unchanged.
- R7: An erase request starts only when `busy` is 0, `full` is 0 and `erase_permit` is 1; otherwise it has no effect.
- R8: `prog_stall` is 1 exactly while an operation on the program array runs, `data_stall` is 1 while any operation runs, and `rd_data` reads 0 while the array picked by `rd_array` is stalled.
- R9: With `rd_byte` = 1, `rd_data` returns the selected byte zero-extended, bits 15:8 of the word when `rd_hi` = 1 and bits 7:0 when `rd_hi` = 0; with `rd_byte` = 0 the whole word is returned.
- R10: Array select 0 addresses the program array and 1 the data array; an operation on one array never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_req | input | 1 | Offer a write request this cycle |
| wr_array | input | 1 | Write target array (0 program, 1 data) |
| wr_addr | input | AW | Write word address |
| wr_data | input | 16 | Write data (bits to keep) |
| erase_req | input | 1 | Request a page erase this cycle |
| erase_array | input | 1 | Erase target array (0 program, 1 data) |
| erase_addr | input | AW | Any word address inside the page to erase |
| erase_permit | input | 1 | Write-enable permit for the addressed page |
| full | output | 1 | Holding slot occupied |
| busy | output | 1 | Operation in progress |
| overrun | output | 1 | Sticky flag: a write was dropped |
| prog_stall | output | 1 | Program array reads blocked |
| data_stall | output | 1 | Data array reads blocked |
| rd_array | input | 1 | Read array select (0 program, 1 data) |
| rd_addr | input | AW | Read word address |
| rd_byte | input | 1 | Byte-size read |
| rd_hi | input | 1 | Upper byte select for byte reads |
| rd_data | output | 16 | Read result |

## Verification
The bench builds the sequencer with a 16-word program array of 8-word pages, an 8-word data array of 4-word pages, 3-cycle writes and 5-cycle erases. At that size every word of both arrays is written twice, read back in both byte lanes and every page of each array erased, all against a model computed in the bench, while each operation's busy duration is counted. The short cycle counts also put the queueing corners in easy reach: a write loaded during a running operation, the idle cycle before it starts, a write dropped on a full slot, erases refused for lack of permit or while the slot or engine is occupied, and the stall behaviour seen from both arrays.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int DW = 16;

  typedef enum logic {
    ARR_PROG = 1'b0,
    ARR_DATA = 1'b1
  } arr_e;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_ERASE = 1'b1
  } kind_e;
endpackage

// File: rtl/flash_req_hold.sv
module flash_req_hold
  import flash_seq_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  arr_e          wr_arr,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          hold_v,
  output arr_e          h_arr,
  output logic [AW-1:0] h_addr,
  output logic [DW-1:0] h_data,
  output logic          overrun
);
  logic          v_q, v_n;
  arr_e          arr_q, arr_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] data_q, data_n;
  logic          ovr_q, ovr_n;
  logic          load;

  assign load = wr_req && !v_q;

  always_comb begin
    v_n    = v_q;
    arr_n  = arr_q;
    addr_n = addr_q;
    data_n = data_q;
    ovr_n  = ovr_q || (wr_req && v_q);
    if (take) v_n = 1'b0;
    if (load) begin
      v_n    = 1'b1;
      arr_n  = wr_arr;
      addr_n = wr_addr;
      data_n = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      arr_q  <= ARR_PROG;
      addr_q <= '0;
      data_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      v_q   <= v_n;
      ovr_q <= ovr_n;
      if (load) begin
        arr_q  <= arr_n;
        addr_q <= addr_n;
        data_q <= data_n;
      end
    end
  end

  assign hold_v  = v_q;
  assign h_arr   = arr_q;
  assign h_addr  = addr_q;
  assign h_data  = data_q;
  assign overrun = ovr_q;

  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  a_r6_drop_keeps_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && hold_v && !take) |=> (hold_v && $stable(h_data) && $stable(h_addr)));
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_seq_pkg::*;
#(
  parameter int AW           = 10,
  parameter int PROG_CYCLES  = 40,
  parameter int ERASE_CYCLES = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_v,
  input  arr_e          h_arr,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_data,
  input  logic          erase_go,
  input  arr_e          e_arr,
  input  logic [AW-1:0] e_addr,
  output logic          take,
  output logic          busy,
  output logic          done,
  output kind_e         op_kind,
  output arr_e          op_arr,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data
);
  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  kind_e         kind_q, kind_n;
  arr_e          arr_q, arr_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] data_q, data_n;
  logic          start;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    kind_n = kind_q;
    arr_n  = arr_q;
    addr_n = addr_q;
    data_n = data_q;
    take   = 1'b0;
    start  = 1'b0;
    done   = busy_q && (cnt_q == '0);
    if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else             cnt_n  = cnt_q - 1'b1;
    end else if (erase_go) begin
      start  = 1'b1;
      busy_n = 1'b1;
      cnt_n  = CW'(ERASE_CYCLES - 1);
      kind_n = OP_ERASE;
      arr_n  = e_arr;
      addr_n = e_addr;
    end else if (hold_v) begin
      start  = 1'b1;
      take   = 1'b1;
      busy_n = 1'b1;
      cnt_n  = CW'(PROG_CYCLES - 1);
      kind_n = OP_WRITE;
      arr_n  = h_arr;
      addr_n = h_addr;
      data_n = h_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= OP_WRITE;
      arr_q  <= ARR_PROG;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      if (start) begin
        kind_q <= kind_n;
        arr_q  <= arr_n;
        addr_q <= addr_n;
        data_q <= data_n;
      end
    end
  end

  assign busy    = busy_q;
  assign op_kind = kind_q;
  assign op_arr  = arr_q;
  assign op_addr = addr_q;
  assign op_data = data_q;

  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(op_addr) && $stable(op_arr)));
  a_r4_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r5_start_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hold_v && !erase_go) |=> (busy && op_kind == OP_WRITE));
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_seq_pkg::*;
#(
  parameter int WORDS      = 1024,
  parameter int PAGE_WORDS = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prog_en,
  input  logic                     erase_en,
  input  logic [$clog2(WORDS)-1:0] op_addr,
  input  logic [DW-1:0]            op_data,
  input  logic [$clog2(WORDS)-1:0] rd_addr,
  output logic [DW-1:0]            rd_word
);
  localparam int IW = $clog2(WORDS);
  localparam int PB = $clog2(PAGE_WORDS);

  logic [DW-1:0] mem [WORDS];
  logic [IW-1:0] page_base;

  assign page_base = {op_addr[IW-1:PB], {PB{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (erase_en) begin
      for (int j = 0; j < PAGE_WORDS; j++) mem[page_base + IW'(j)] <= '1;
    end else if (prog_en) begin
      mem[op_addr] <= mem[op_addr] & op_data;
    end
  end

  assign rd_word = mem[rd_addr];

  a_r2_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> ((mem[$past(op_addr)] & ~$past(mem[op_addr])) == '0));
  a_r3_erased_ones: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> (mem[$past(op_addr)] == '1));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int PROG_WORDS      = 1024,
  parameter int PROG_PAGE_WORDS = 512,
  parameter int DATA_WORDS      = 1024,
  parameter int DATA_PAGE_WORDS = 256,
  parameter int PROG_CYCLES     = 40,
  parameter int ERASE_CYCLES    = 2000,
  localparam int PAW = $clog2(PROG_WORDS),
  localparam int DAW = $clog2(DATA_WORDS),
  localparam int AW  = (PAW > DAW) ? PAW : DAW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          wr_array,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          erase_req,
  input  logic          erase_array,
  input  logic [AW-1:0] erase_addr,
  input  logic          erase_permit,
  output logic          full,
  output logic          busy,
  output logic          overrun,
  output logic          prog_stall,
  output logic          data_stall,
  input  logic          rd_array,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_byte,
  input  logic          rd_hi,
  output logic [15:0]   rd_data
);
  logic [1:0]    rst_sync_q;
  logic          rst_i_n;
  logic          take, done, hold_v, erase_go;
  arr_e          h_arr, op_arr;
  kind_e         op_kind;
  logic [AW-1:0] h_addr, op_addr;
  logic [DW-1:0] h_data, op_data;
  logic [DW-1:0] p_word, d_word, sel_word;
  logic          sel_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  flash_req_hold #(.AW(AW)) u_hold (
    .clk(clk), .rst_n(rst_i_n), .wr_req(wr_req), .wr_arr(arr_e'(wr_array)),
    .wr_addr(wr_addr), .wr_data(wr_data), .take(take), .hold_v(hold_v),
    .h_arr(h_arr), .h_addr(h_addr), .h_data(h_data), .overrun(overrun)
  );

  assign erase_go = erase_req && erase_permit && !busy && !hold_v;

  flash_op_timer #(.AW(AW), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .hold_v(hold_v), .h_arr(h_arr), .h_addr(h_addr),
    .h_data(h_data), .erase_go(erase_go), .e_arr(arr_e'(erase_array)),
    .e_addr(erase_addr), .take(take), .busy(busy), .done(done),
    .op_kind(op_kind), .op_arr(op_arr), .op_addr(op_addr), .op_data(op_data)
  );

  flash_array #(.WORDS(PROG_WORDS), .PAGE_WORDS(PROG_PAGE_WORDS)) u_prog (
    .clk(clk), .rst_n(rst_i_n),
    .prog_en(done && op_arr == ARR_PROG && op_kind == OP_WRITE),
    .erase_en(done && op_arr == ARR_PROG && op_kind == OP_ERASE),
    .op_addr(op_addr[PAW-1:0]), .op_data(op_data),
    .rd_addr(rd_addr[PAW-1:0]), .rd_word(p_word)
  );

  flash_array #(.WORDS(DATA_WORDS), .PAGE_WORDS(DATA_PAGE_WORDS)) u_data (
    .clk(clk), .rst_n(rst_i_n),
    .prog_en(done && op_arr == ARR_DATA && op_kind == OP_WRITE),
    .erase_en(done && op_arr == ARR_DATA && op_kind == OP_ERASE),
    .op_addr(op_addr[DAW-1:0]), .op_data(op_data),
    .rd_addr(rd_addr[DAW-1:0]), .rd_word(d_word)
  );

  assign full       = hold_v;
  assign prog_stall = busy && (op_arr == ARR_PROG);
  assign data_stall = busy;

  always_comb begin
    sel_stall = rd_array ? data_stall : prog_stall;
    sel_word  = rd_array ? d_word : p_word;
    if (sel_stall)    rd_data = '0;
    else if (rd_byte) rd_data = {8'h00, rd_hi ? sel_word[15:8] : sel_word[7:0]};
    else              rd_data = sel_word;
  end

  a_r7_no_erase_without_permit: assert property (@(posedge clk) disable iff (!rst_i_n)
    (erase_req && !erase_permit && !busy && !full) |=> !busy);
  a_r8_stalled_reads_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (data_stall && rd_array) |-> (rd_data == '0));
endmodule

// File: tb/tb_flash_seq.sv
module tb_flash_seq;
  localparam int PW = 16, PPG = 8, DWD = 8, DPG = 4, PC = 3, EC = 5;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_req = 0, wr_array = 0, erase_req = 0, erase_array = 0, erase_permit = 0;
  logic [AW-1:0] wr_addr = '0, erase_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic rd_array = 0, rd_byte = 0, rd_hi = 0;
  logic full, busy, overrun, prog_stall, data_stall;
  logic [15:0] rd_data;

  int total = 0, bad = 0;
  logic [15:0] m_p [PW];
  logic [15:0] m_d [DWD];

  always #5 clk = ~clk;

  flash_seq #(.PROG_WORDS(PW), .PROG_PAGE_WORDS(PPG), .DATA_WORDS(DWD),
              .DATA_PAGE_WORDS(DPG), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_array(wr_array), .wr_addr(wr_addr),
    .wr_data(wr_data), .erase_req(erase_req), .erase_array(erase_array),
    .erase_addr(erase_addr), .erase_permit(erase_permit), .full(full), .busy(busy),
    .overrun(overrun), .prog_stall(prog_stall), .data_stall(data_stall),
    .rd_array(rd_array), .rd_addr(rd_addr), .rd_byte(rd_byte), .rd_hi(rd_hi),
    .rd_data(rd_data)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mval(logic a, int i);
    return a ? m_d[i] : m_p[i];
  endfunction

  task automatic rd(logic a, int i, logic by, logic hi, output logic [15:0] v);
    rd_array = a; rd_addr = AW'(i); rd_byte = by; rd_hi = hi;
    #1 v = rd_data;
  endtask

  task automatic check_all(string tag);
    logic [15:0] v;
    for (int i = 0; i < PW; i++) begin rd(1'b0, i, 1'b0, 1'b0, v); check(tag, v, m_p[i]); end
    for (int i = 0; i < DWD; i++) begin rd(1'b1, i, 1'b0, 1'b0, v); check(tag, v, m_d[i]); end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic do_write(logic a, int i, logic [15:0] d);
    int n;
    @(negedge clk);
    wr_req = 1; wr_array = a; wr_addr = AW'(i); wr_data = d;
    @(negedge clk);
    wr_req = 0;
    check("R5 full after load", full, 1);
    @(negedge clk);
    wait_idle(n);
    check("R4 write busy cycles", n, PC);
    if (a) m_d[i] = m_d[i] & d; else m_p[i] = m_p[i] & d;
  endtask

  task automatic do_erase(logic a, int i, logic permit);
    int n, base, pg;
    @(negedge clk);
    erase_req = 1; erase_array = a; erase_addr = AW'(i); erase_permit = permit;
    @(negedge clk);
    erase_req = 0; erase_permit = 0;
    wait_idle(n);
    if (permit) check("R4 erase busy cycles", n, EC);
    else        check("R7 erase without permit", n, 0);
    if (permit) begin
      pg = a ? DPG : PPG;
      base = (i / pg) * pg;
      for (int k = base; k < base + pg; k++) if (a) m_d[k] = '1; else m_p[k] = '1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    for (int i = 0; i < PW; i++) m_p[i] = '1;
    for (int i = 0; i < DWD; i++) m_d[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 full", full, 0);
    check("R1 busy", busy, 0);
    check("R1 overrun", overrun, 0);
    check_all("R1 erased contents");

    // R2 / R10: two writes per word in each array, AND accumulation
    for (int a = 0; a < 2; a++) begin
      for (int i = 0; i < (a ? DWD : PW); i++) begin
        do_write(a[0], i, 16'(i * 16'h1357) ^ 16'hA5C3 ^ 16'(a * 16'h0F0F));
        rd(a[0], i, 1'b0, 1'b0, v); check("R2 first write", v, mval(a[0], i));
        do_write(a[0], i, ~(16'h0001 << (i % 16)) & 16'hF7FF);
        rd(a[0], i, 1'b0, 1'b0, v); check("R2 AND second write", v, mval(a[0], i));
      end
      check_all("R10 other array untouched");
    end

    // R9 byte reads in both lanes
    for (int a = 0; a < 2; a++)
      for (int i = 0; i < (a ? DWD : PW); i++) begin
        rd(a[0], i, 1'b1, 1'b0, v); check("R9 low byte", v, {8'h00, mval(a[0], i) & 16'h00FF} & 16'h00FF);
        rd(a[0], i, 1'b1, 1'b1, v); check("R9 high byte", v, {8'h00, mval(a[0], i) >> 8} & 16'h00FF);
      end

    // R7 erase without permit has no effect
    do_erase(1'b0, 3, 1'b0);
    do_erase(1'b1, 5, 1'b0);
    check_all("R7 contents after refused erase");

    // R3 erase each page via a non-base address
    do_erase(1'b0, 10, 1'b1);
    check_all("R3 program page 1 erased");
    do_erase(1'b1, 1, 1'b1);
    check_all("R3 data page 0 erased");

    // R7 erase refused while slot full and while busy
    @(negedge clk);
    wr_req = 1; wr_array = 0; wr_addr = 4'd12; wr_data = 16'h00FF;
    @(negedge clk);
    wr_req = 0;
    erase_req = 1; erase_array = 0; erase_addr = 4'd2; erase_permit = 1;
    @(negedge clk);
    check("R7 busy from write", busy, 1);
    @(negedge clk);
    erase_req = 0; erase_permit = 0;
    wait_idle(n);
    m_p[12] = m_p[12] & 16'h00FF;
    @(negedge clk);
    check("R7 no erase after refused request", busy, 0);
    check_all("R7 contents after erase during write");

    // R5 / R6 / R8 pipelining, overrun, stalls
    @(negedge clk);
    wr_req = 1; wr_array = 0; wr_addr = 4'd3; wr_data = 16'h5A5A;
    @(negedge clk);
    wr_req = 0;
    check("R5 held, not yet running", busy, 0);
    @(negedge clk);
    check("R4 busy on start", busy, 1);
    check("R5 slot freed on start", full, 0);
    check("R8 prog stall on program op", prog_stall, 1);
    check("R8 data stall on program op", data_stall, 1);
    rd(1'b0, 3, 1'b0, 1'b0, v); check("R8 stalled program read", v, 0);
    rd(1'b1, 2, 1'b0, 1'b0, v); check("R8 stalled data read", v, 0);
    wr_req = 1; wr_array = 1; wr_addr = 4'd2; wr_data = 16'h3C3C;
    @(negedge clk);
    wr_req = 0;
    check("R5 load during busy", full, 1);
    check("R5 still busy", busy, 1);
    wr_req = 1; wr_array = 0; wr_addr = 4'd5; wr_data = 16'h0000;
    @(negedge clk);
    wr_req = 0;
    check("R6 overrun set", overrun, 1);
    check("R6 slot still full", full, 1);
    wait_idle(n);
    m_p[3] = m_p[3] & 16'h5A5A;
    check("R5 idle cycle with held write", full, 1);
    @(negedge clk);
    check("R5 held write starts", busy, 1);
    check("R5 slot empties", full, 0);
    check("R8 no prog stall on data op", prog_stall, 0);
    check("R8 data stall on data op", data_stall, 1);
    rd(1'b0, 3, 1'b0, 1'b0, v); check("R8 program read during data op", v, m_p[3]);
    rd(1'b1, 2, 1'b0, 1'b0, v); check("R8 data read stalled", v, 0);
    wait_idle(n);
    m_d[2] = m_d[2] & 16'h3C3C;
    check_all("R6 dropped write absent");
    repeat (3) @(negedge clk);
    check("R6 overrun sticky", overrun, 1);

    // R3 erase remaining pages, full sweep
    do_erase(1'b0, 0, 1'b1);
    do_erase(1'b1, 7, 1'b1);
    check_all("R3 all pages erased");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule